// File: doc/BRIEF.md
# Split-Phase Register File with Paired Write

This block is the general register store of a five-stage integer pipeline: thirty-two words of thirty-two bits, two combinational read ports used by the decode stage, and one write-back port. Register zero is a constant zero. A write presented in a cycle is visible on the read ports in that same cycle, as if the write happened in the first half of the clock and the reads in the second half. Decode therefore never needs a separate bypass from write-back.

The write-back port can carry a second word for a widening multiply. This multiply uses the opcode and function code of the ordinary signed multiply, but its 64-bit product goes into the general registers, not into dedicated high/low registers. The low word goes to the destination index and the high word goes to the next index up. Both words are committed in one clock, and both are passed through to the readers in that clock.

A paired write aimed at the top register has no room for its high word. The high word is dropped rather than wrapped to register zero, and a sticky error flag is raised. A synchronous reset clears the registers and the flag.

Top module: `gpr_file`

## Requirements
- R1: A write with `wr_en` high and `wr_idx` not zero stores `wr_data`. From the next cycle on, any read of that index returns it until the register is written again.
- R2: Reading index 0 returns zero on either port. A write to index 0 changes nothing that can be read.
- R3: In the cycle a write is presented, a read port whose index equals `wr_idx` (not 0) shows `wr_data` instead of the stored value.
- R4: With `wr_en` and `pair_en` both high, `wr_data` goes to `wr_idx` and `pair_data` goes to index `wr_idx`+1, both in the same clock.
- R5: In the cycle a paired write is presented, a read port whose index equals `wr_idx`+1 shows `pair_data`. A read port whose index equals `wr_idx` shows `wr_data`.
- R6: A paired write with `wr_idx` = 31 still stores the low word in register 31. The high word is dropped: register 0 still reads zero and no register changes except 31. `pair_err` goes high on the next cycle and stays high until reset.
- R7: A paired write with `wr_idx` = 0 discards the low word and still writes `pair_data` into register 1.
- R8: While `rst` is high at a clock edge, all registers are cleared to zero and `pair_err` is cleared. This takes effect from the next cycle.
- R9: The two read ports are independent and can show different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | 5 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_idx_b | input | 5 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write-back enable |
| wr_idx | input | 5 | Write-back destination index (low word) |
| wr_data | input | 32 | Write-back data (low word) |
| pair_en | input | 1 | Also write `pair_data` to `wr_idx`+1 |
| pair_data | input | 32 | High word of a paired write |
| pair_err | output | 1 | Sticky flag: paired write hit the top register |

## Verification
A register that is corrupted or written to the wrong index shows up the first time either read port selects it. The bench reads back every written index, and its neighbours, in the cycle after the write. A fault in the pass-through is only visible during the write cycle itself, so the bench samples the read ports while the write is still being driven. A wrongly wrapped high word would show as a nonzero register 0 or a changed register 1 right after the top-index paired write. A stuck or unset error flag is visible one cycle after the trigger.

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_idx_a,
  output logic [W-1:0]  rd_data_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [W-1:0]  rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          pair_en,
  input  logic [W-1:0]  pair_data,
  output logic          pair_err
);

  logic [W-1:0]  regs [NREG];
  logic [AW-1:0] hi_idx;
  logic          top_hit, lo_we, hi_we;

  assign hi_idx  = wr_idx + 1'b1;
  assign top_hit = (wr_idx == AW'(NREG - 1));
  assign lo_we   = wr_en && (wr_idx != '0);
  assign hi_we   = wr_en && pair_en && !top_hit;

  function automatic logic [W-1:0] rd_sel(input logic [AW-1:0] idx);
    if (idx == '0)                  return '0;
    else if (hi_we && idx == hi_idx) return pair_data;
    else if (lo_we && idx == wr_idx) return wr_data;
    else                            return regs[idx];
  endfunction

  assign rd_data_a = rd_sel(rd_idx_a);
  assign rd_data_b = rd_sel(rd_idx_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      pair_err <= 1'b0;
    end else begin
      if (lo_we) regs[wr_idx] <= wr_data;
      if (hi_we) regs[hi_idx] <= pair_data;
      if (wr_en && pair_en && top_hit) pair_err <= 1'b1;
    end
  end

endmodule

module gpr_file_chk #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rd_idx_a,
  input logic [W-1:0]  rd_data_a,
  input logic [AW-1:0] rd_idx_b,
  input logic [W-1:0]  rd_data_b,
  input logic          wr_en,
  input logic [AW-1:0] wr_idx,
  input logic [W-1:0]  wr_data,
  input logic          pair_en,
  input logic [W-1:0]  pair_data,
  input logic          pair_err
);

  logic seen_clk = 1'b0;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  a_r2_zero_a: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    rd_idx_a == '0 |-> rd_data_a == '0);
  a_r2_zero_b: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    rd_idx_b == '0 |-> rd_data_b == '0);

  a_r3_pass_a: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    (wr_en && wr_idx != '0 && rd_idx_a == wr_idx) |-> rd_data_a == wr_data);

  a_r5_pair_pass_b: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    (wr_en && pair_en && wr_idx != AW'(NREG-1) && rd_idx_b == AW'(wr_idx + 1'b1))
      |-> rd_data_b == pair_data);

  a_r1_lands: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    ($past(wr_en) && !$past(pair_en) && !$past(rst) && $past(wr_idx) != '0 &&
     !wr_en && rd_idx_a == $past(wr_idx)) |-> rd_data_a == $past(wr_data));

  a_r6_err_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pair_en && wr_idx == AW'(NREG-1)) |=> pair_err);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    pair_err |=> pair_err);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !pair_err);

endmodule

bind gpr_file gpr_file_chk #(.NREG(NREG), .W(W)) chk_i (
  .clk(clk), .rst(rst), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
  .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_data(wr_data), .pair_en(pair_en), .pair_data(pair_data), .pair_err(pair_err)
);

// File: tb/gpr_file_tb_top.sv
`timescale 1ns/1ps
module gpr_file_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0, pair_data = '0;
  logic        wr_en = 1'b0, pair_en = 1'b0, pair_err;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  gpr_file dut_i (
    .clk(clk), .rst(rst), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .pair_en(pair_en), .pair_data(pair_data), .pair_err(pair_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive a write at the falling edge; it commits at the next rising edge.
  task automatic put(input logic [4:0] idx, input logic [31:0] lo,
                     input logic pr, input logic [31:0] hi);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = lo; pair_en = pr; pair_data = hi;
    @(posedge clk); #1;
    wr_en = 1'b0; pair_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ia, input logic [4:0] ib);
    rd_idx_a = ia; rd_idx_b = ib; #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    for (int i = 0; i < 32; i++) begin
      rd(5'(i), 5'(31 - i));
      chk("R8 reg clear A", rd_data_a, 0);
      chk("R8 reg clear B", rd_data_b, 0);
    end
    chk("R8 err clear", {31'b0, pair_err}, 0);
  endtask

  task automatic t_basic();
    for (int i = 1; i < 32; i++) put(5'(i), 32'h1000_0000 + 32'(i * 7), 1'b0, 0);
    for (int i = 1; i < 32; i++) begin
      rd(5'(i), 5'(i));
      chk("R1 write lands", rd_data_a, 32'h1000_0000 + 32'(i * 7));
    end
    put(5'd9, 32'hCAFE_0009, 1'b0, 0);
    rd(5'd9, 5'd8);
    chk("R1 overwrite", rd_data_a, 32'hCAFE_0009);
    chk("R1 neighbour kept", rd_data_b, 32'h1000_0000 + 32'(8 * 7));
  endtask

  task automatic t_zero();
    put(5'd0, 32'hFFFF_FFFF, 1'b0, 0);
    rd(5'd0, 5'd0);
    chk("R2 zero A", rd_data_a, 0);
    chk("R2 zero B", rd_data_b, 0);
    @(negedge clk); wr_en = 1'b1; wr_idx = 0; wr_data = 32'h1234_5678; rd(5'd0, 5'd1);
    chk("R2 zero during write", rd_data_a, 0);
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic t_bypass();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd12; wr_data = 32'hB1B1_0012; pair_en = 1'b0;
    rd(5'd12, 5'd12);
    chk("R3 pass A", rd_data_a, 32'hB1B1_0012);
    chk("R3 pass B", rd_data_b, 32'hB1B1_0012);
    rd(5'd13, 5'd12);
    chk("R3 other idx stored", rd_data_a, 32'h1000_0000 + 32'(13 * 7));
    @(posedge clk); #1; wr_en = 1'b0;
    rd(5'd12, 5'd0);
    chk("R3 committed", rd_data_a, 32'hB1B1_0012);
  endtask

  task automatic t_pair();
    put(5'd20, 32'hAAAA_0020, 1'b1, 32'h5555_0021);
    rd(5'd20, 5'd21);
    chk("R4 low word", rd_data_a, 32'hAAAA_0020);
    chk("R4 high word", rd_data_b, 32'h5555_0021);
    rd(5'd22, 5'd19);
    chk("R4 above untouched", rd_data_a, 32'h1000_0000 + 32'(22 * 7));
    chk("R4 below untouched", rd_data_b, 32'h1000_0000 + 32'(19 * 7));
  endtask

  task automatic t_pair_bypass();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd4; wr_data = 32'h0404_0404; pair_en = 1'b1; pair_data = 32'h0505_0505;
    rd(5'd5, 5'd4);
    chk("R5 pass high", rd_data_a, 32'h0505_0505);
    chk("R5 pass low", rd_data_b, 32'h0404_0404);
    @(posedge clk); #1; wr_en = 1'b0; pair_en = 1'b0;
  endtask

  task automatic t_pair_top();
    chk("R6 err low before", {31'b0, pair_err}, 0);
    put(5'd31, 32'h3131_3131, 1'b1, 32'hDEAD_BEEF);
    rd(5'd31, 5'd0);
    chk("R6 low kept", rd_data_a, 32'h3131_3131);
    chk("R6 no wrap reg0", rd_data_b, 0);
    rd(5'd1, 5'd30);
    chk("R6 reg1 untouched", rd_data_a, 32'h1000_0007);
    chk("R6 reg30 untouched", rd_data_b, 32'h1000_0000 + 32'(30 * 7));
    chk("R6 err set", {31'b0, pair_err}, 1);
    put(5'd3, 32'h3, 1'b0, 0);
    chk("R6 err sticky", {31'b0, pair_err}, 1);
  endtask

  task automatic t_pair_zero();
    put(5'd0, 32'hEEEE_EEEE, 1'b1, 32'h0101_0101);
    rd(5'd0, 5'd1);
    chk("R7 low discarded", rd_data_a, 0);
    chk("R7 high to reg1", rd_data_b, 32'h0101_0101);
  endtask

  task automatic t_ports();
    rd(5'd20, 5'd9);
    chk("R9 port A", rd_data_a, 32'hAAAA_0020);
    chk("R9 port B", rd_data_b, 32'hCAFE_0009);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    t_reset();
    t_basic();
    t_zero();
    t_bypass();
    t_pair();
    t_pair_bypass();
    t_pair_top();
    t_pair_zero();
    t_ports();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule